// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flag Interrupts

This block turns an asynchronous serial line into characters. The line is sampled at sixteen times the bit rate, and each bit is settled by a vote of three samples taken near its centre. A completed character is placed in a holding register that the CPU reads through a small address-decoded port. Four status flags track the receiver's state: character ready, line idle, overrun and noise. Each flag has its own enable bit. The ready and idle flags share one receiver interrupt line. The overrun and noise flags share a separate error interrupt line.

Software chooses whether characters carry 8 or 9 data bits. It also chooses where idle counting begins: as soon as the start bit has passed, or only once the stop bit has passed. A standby bit lets the CPU ignore traffic until the line goes idle. While standby is set, characters are thrown away and both interrupt lines are held low. When an idle line is seen, the hardware clears standby itself. The bit-rate enable is supplied from outside the block as a one-cycle tick at sixteen times the bit rate.

Top module: `uart_rx_stat`

## Requirements
- R1: A frame is one low start bit, then 8 data bits (or 9 when control bit 0 is set), least significant bit first, then a stop bit. When the stop bit has been sampled, the character goes to data registers 2 (bits 7:0) and 3 (bit 0 holds data bit 8), and status bit 0 (ready) is set.
- R2: `rx_irq` is high when ready is set and control bit 4 is set, or when idle is set and control bit 5 is set.
- R3: Each bit takes the majority of oversamples 7, 8 and 9, counted from the start edge. If these three samples disagree on any start, data or stop bit of a delivered character, status bit 3 (noise) is set. The character value is still the majority value.
- R4: `err_irq` is high when overrun is set and control bit 6 is set, or when noise is set and control bit 7 is set.
- R5: If a character completes while ready is still set, status bit 2 (overrun) is set. The old character stays in the data registers and the new one is lost.
- R6: Reading register 1 (status) and then reading register 2 clears the ready, idle, overrun and noise flags.
- R7: Status bit 1 (idle) is set after 10 bit times of continuous ones with 8-bit characters, or 11 bit times with 9-bit characters. With control bit 1 clear, counting may begin right after the start bit. With control bit 1 set, counting begins only once the stop bit has been sampled.
- R8: Once the idle flag has been set, it is not set again until at least one more character has been received.
- R9: Control bit 2 is standby. While it is set, completed characters are discarded and both interrupt lines stay low. An idle line clears standby. If standby is set while the line is already idle, it clears within a few cycles.
- R10: After reset, every register reads zero and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial data line, idles high |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data low, 3 data high |
| wr_en | input | 1 | Write strobe, only the control register is writable |
| rd_en | input | 1 | Read strobe, used for the flag-clear sequence |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| rx_irq | output | 1 | Receiver interrupt (ready or idle) |
| err_irq | output | 1 | Error interrupt (overrun or noise) |

## Verification
On every cycle the assertions check the following. Ready rises only when the frame engine delivers a character. An overrun leaves the held character unchanged. A character that arrives in standby never reaches the data registers. The idle flag rises only after a new character. An idle line takes the receiver out of standby. The clear sequence empties the flags. The bit index and the idle counter stay in range. Some behaviour needs whole scenarios, and the bench's scenarios show it: the data values themselves, whether noise is detected when a single sample glitches, the exact bit time at which idle appears under each counting mode and character length, and an immediate wake-up when standby is set on a line that is already quiet.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } frame_st_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DLO  = 2'd2;
  localparam logic [1:0] A_DHI  = 2'd3;

  localparam int B_CHAR9  = 0;
  localparam int B_ISTOP  = 1;
  localparam int B_STBY   = 2;
  localparam int B_FIE    = 4;
  localparam int B_IIE    = 5;
  localparam int B_OIE    = 6;
  localparam int B_NIE    = 7;
endpackage

// File: rtl/urx_frame.sv
module urx_frame
  import urx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic       char9,
  output logic       done,
  output logic       noisy,
  output logic       busy,
  output logic [8:0] data
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] P_LAST = PW'(OSR - 1);
  localparam logic [PW-1:0] P_A    = PW'(OSR / 2 - 1);
  localparam logic [PW-1:0] P_B    = PW'(OSR / 2);
  localparam logic [PW-1:0] P_C    = PW'(OSR / 2 + 1);

  frame_st_e       state_q, state_n;
  logic [PW-1:0]   phase_q, phase_n;
  logic [3:0]      bitn_q, bitn_n;
  logic [8:0]      shreg_q, shreg_n;
  logic [1:0]      v_q, v_n;
  logic            nz_q, nz_n;
  logic            maj, dis;
  logic [3:0]      last_bit;

  assign maj      = (v_q[0] & v_q[1]) | (v_q[0] & rxd_s) | (v_q[1] & rxd_s);
  assign dis      = (v_q[0] != v_q[1]) || (v_q[1] != rxd_s);
  assign last_bit = char9 ? 4'd8 : 4'd7;
  assign busy     = (state_q != FR_IDLE);
  assign data     = char9 ? shreg_q : {1'b0, shreg_q[8:1]};
  assign noisy    = nz_q | dis;

  always_comb begin
    state_n = state_q;
    phase_n = phase_q;
    bitn_n  = bitn_q;
    shreg_n = shreg_q;
    v_n     = v_q;
    nz_n    = nz_q;
    done    = 1'b0;
    if (tick) begin
      if (state_q == FR_IDLE) begin
        if (!rxd_s) begin
          state_n = FR_START;
          phase_n = PW'(1);
          nz_n    = 1'b0;
        end
      end else begin
        phase_n = (phase_q == P_LAST) ? '0 : phase_q + PW'(1);
        if (phase_q == P_A) v_n[0] = rxd_s;
        if (phase_q == P_B) v_n[1] = rxd_s;
        unique case (state_q)
          FR_START: begin
            if (phase_q == P_C) begin
              if (maj) state_n = FR_IDLE;
              else     nz_n    = nz_q | dis;
            end else if (phase_q == P_LAST) begin
              state_n = FR_DATA;
              bitn_n  = 4'd0;
            end
          end
          FR_DATA: begin
            if (phase_q == P_C) begin
              shreg_n = {maj, shreg_q[8:1]};
              nz_n    = nz_q | dis;
            end else if (phase_q == P_LAST) begin
              if (bitn_q == last_bit) state_n = FR_STOP;
              else                    bitn_n  = bitn_q + 4'd1;
            end
          end
          FR_STOP: begin
            if (phase_q == P_C) begin
              done    = 1'b1;
              state_n = FR_IDLE;
            end
          end
          default: state_n = FR_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      phase_q <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      v_q     <= 2'b11;
      nz_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      bitn_q  <= bitn_n;
      shreg_q <= shreg_n;
      v_q     <= v_n;
      nz_q    <= nz_n;
    end
  end

  AST_BIT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_DATA) |-> (bitn_q <= 4'd8)); // R1
endmodule

// File: rtl/urx_idle.sv
module urx_idle #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd_s,
  input  logic busy,
  input  logic after_stop,
  input  logic char9,
  output logic hit
);
  localparam int CW = $clog2(11 * OSR + 1);
  localparam logic [CW-1:0] THR8 = CW'(10 * OSR);
  localparam logic [CW-1:0] THR9 = CW'(11 * OSR);

  logic [CW-1:0] cnt_q, cnt_n, thr;

  assign thr = char9 ? THR9 : THR8;
  assign hit = (cnt_q >= thr);

  always_comb begin
    cnt_n = cnt_q;
    if (!rxd_s || (after_stop && busy)) cnt_n = '0;
    else if (tick && (cnt_q < thr))     cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  AST_IDLE_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= THR9); // R7
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import urx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rx_irq,
  output logic       err_irq
);
  logic [1:0]             rst_pipe;
  logic                   rst_s;
  logic [SYNC_STAGES-1:0] rx_pipe;
  logic                   rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_s) begin
        if (!rst_s) rx_pipe <= '1;
        else        rx_pipe <= rxd;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_s) begin
        if (!rst_s) rx_pipe <= '1;
        else        rx_pipe <= {rx_pipe[SYNC_STAGES-2:0], rxd};
      end
    end
  endgenerate
  assign rxd_s = rx_pipe[SYNC_STAGES-1];

  logic [7:0] ctrl_q, ctrl_n;
  logic       full_q, full_n, idle_q, idle_n, ovr_q, ovr_n, noise_q, noise_n;
  logic [8:0] data_q, data_n;
  logic       armed_q, armed_n, rearm_q, rearm_n, hit_q;
  logic       fr_done, fr_noisy, fr_busy, idle_hit;
  logic [8:0] fr_data;
  logic       stby, wr_ctrl, rd_stat, rd_data, clr;

  urx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_s), .tick(os_tick), .rxd_s(rxd_s),
    .char9(ctrl_q[B_CHAR9]), .done(fr_done), .noisy(fr_noisy),
    .busy(fr_busy), .data(fr_data)
  );

  urx_idle #(.OSR(OSR)) u_idle (
    .clk(clk), .rst_n(rst_s), .tick(os_tick), .rxd_s(rxd_s),
    .busy(fr_busy), .after_stop(ctrl_q[B_ISTOP]),
    .char9(ctrl_q[B_CHAR9]), .hit(idle_hit)
  );

  assign stby    = ctrl_q[B_STBY];
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign rd_stat = rd_en && (addr == A_STAT);
  assign rd_data = rd_en && (addr == A_DLO);
  assign clr     = rd_data && armed_q;

  always_comb begin
    ctrl_n  = ctrl_q;
    armed_n = armed_q;
    full_n  = full_q;
    idle_n  = idle_q;
    ovr_n   = ovr_q;
    noise_n = noise_q;
    data_n  = data_q;
    rearm_n = rearm_q;
    if (wr_ctrl)                ctrl_n = wdata;
    else if (stby && idle_hit)  ctrl_n[B_STBY] = 1'b0;
    if (rd_stat)      armed_n = 1'b1;
    else if (rd_data) armed_n = 1'b0;
    if (clr) begin
      full_n  = 1'b0;
      idle_n  = 1'b0;
      ovr_n   = 1'b0;
      noise_n = 1'b0;
    end
    if (fr_done && !stby) begin
      rearm_n = 1'b1;
      if (full_n) begin
        ovr_n = 1'b1;
      end else begin
        full_n  = 1'b1;
        data_n  = fr_data;
        noise_n = noise_n | fr_noisy;
      end
    end
    if (idle_hit && !hit_q && rearm_q && !stby) begin
      idle_n  = 1'b1;
      rearm_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      full_q  <= 1'b0;
      idle_q  <= 1'b0;
      ovr_q   <= 1'b0;
      noise_q <= 1'b0;
      data_q  <= '0;
      rearm_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      armed_q <= armed_n;
      full_q  <= full_n;
      idle_q  <= idle_n;
      ovr_q   <= ovr_n;
      noise_q <= noise_n;
      data_q  <= data_n;
      rearm_q <= rearm_n;
      hit_q   <= idle_hit;
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_STAT:  rdata = {4'b0000, noise_q, ovr_q, idle_q, full_q};
      A_DLO:   rdata = data_q[7:0];
      default: rdata = {7'b0000000, data_q[8]};
    endcase
  end

  assign rx_irq  = !stby && ((full_q && ctrl_q[B_FIE]) || (idle_q && ctrl_q[B_IIE]));
  assign err_irq = !stby && ((ovr_q && ctrl_q[B_OIE]) || (noise_q && ctrl_q[B_NIE]));

  AST_FULL_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(full_q) |-> $past(fr_done)); // R1
  AST_OVR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_s)
    (fr_done && full_q && !clr && !stby) |=> ($stable(data_q) && ovr_q)); // R5
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_s)
    (clr && !fr_done) |=> (!full_q && !ovr_q && !noise_q)); // R6
  AST_IDLE_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(idle_q) |-> $past(rearm_q)); // R8
  AST_STBY_DISCARD: assert property (@(posedge clk) disable iff (!rst_s)
    (fr_done && stby) |=> $stable(data_q)); // R9
  AST_WAKE_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    (stby && idle_hit && !wr_ctrl) |=> !ctrl_q[B_STBY]); // R9
endmodule

// File: tb/uart_rx_stat_bench.sv
`timescale 1ns/1ps
module uart_rx_stat_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick;
  logic       rxd;
  logic [1:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       rx_irq, err_irq;

  int nchk  = 0;
  int nfail = 0;
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;
  assign os_tick = 1'b1;

  uart_rx_stat u_uart_rx_stat (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    addr = 2'd0; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_flags();
    logic [7:0] t;
    rd(2'd1, t);
    rd(2'd2, t);
  endtask

  task automatic send(input logic [8:0] d, input bit c9, input int gl);
    int nb;
    nb = c9 ? 9 : 8;
    for (int k = 0; k <= nb + 1; k++) begin
      logic val;
      val = (k == 0) ? 1'b0 : (k == nb + 1) ? 1'b1 : d[k-1];
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        rxd = (k == gl && c == 8) ? ~val : val;
      end
    end
  endtask

  task automatic monitor(input int n);
    logic [7:0] s, h, l;
    logic [8:0] e;
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!rx_irq);
      rd(2'd1, s);
      chk("R1 ready flag", {31'b0, s[0]}, 1);
      rd(2'd3, h);
      rd(2'd2, l);
      e = exp_q.pop_front();
      chk("R1 scoreboard char", {23'b0, h[0], l}, {23'b0, e});
    end
  endtask

  initial begin
    logic [7:0] s, v;
    rst_n = 1'b0; rxd = 1'b1; addr = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
    idle_wait(5);
    rst_n = 1'b1;
    idle_wait(5);

    // R10 reset state
    rd(2'd0, v); chk("R10 ctrl", v, 0);
    rd(2'd1, v); chk("R10 status", v, 0);
    rd(2'd2, v); chk("R10 data", v, 0);
    chk("R10 irqs", {30'b0, rx_irq, err_irq}, 0);
    idle_wait(200);

    // R1 scoreboard, 8-bit then 9-bit characters
    wr(8'h10);
    fork
      begin
        exp_q.push_back(9'h05A); send(9'h05A, 0, -1);
        exp_q.push_back(9'h0A5); send(9'h0A5, 0, -1);
        exp_q.push_back(9'h001); send(9'h001, 0, -1);
      end
      monitor(3);
    join
    wr(8'h11);
    fork
      begin
        exp_q.push_back(9'h1C3); send(9'h1C3, 1, -1);
        exp_q.push_back(9'h0FF); send(9'h0FF, 1, -1);
      end
      monitor(2);
    join
    chk("R1 queue drained", exp_q.size(), 0);
    idle_wait(400); clr_flags();

    // R2 ready interrupt gated by its enable
    wr(8'h00);
    send(9'h033, 0, -1); idle_wait(20);
    chk("R2 no irq when disabled", {31'b0, rx_irq}, 0);
    rd(2'd1, s); chk("R2 ready set", {31'b0, s[0]}, 1);
    wr(8'h10);
    chk("R2 irq when enabled", {31'b0, rx_irq}, 1);
    clr_flags();
    rd(2'd1, s); chk("R6 flags clear", {28'b0, s[3:0] & 4'b1101}, 0);
    idle_wait(400); clr_flags();

    // R5 R4 overrun keeps old character
    wr(8'h40);
    send(9'h011, 0, -1); send(9'h022, 0, -1); idle_wait(5);
    chk("R4 err irq on overrun", {31'b0, err_irq}, 1);
    rd(2'd1, s); chk("R5 overrun flag", {31'b0, s[2]}, 1);
    rd(2'd2, v); chk("R5 old data kept", v, 8'h11);
    rd(2'd1, s); chk("R6 cleared after sequence", {28'b0, s[3:0] & 4'b1101}, 0);
    idle_wait(400); clr_flags();

    // R3 noise detection
    wr(8'h80);
    send(9'h06C, 0, -1); idle_wait(5);
    rd(2'd1, s); chk("R3 clean frame no noise", {31'b0, s[3]}, 0);
    chk("R4 no err irq", {31'b0, err_irq}, 0);
    clr_flags();
    send(9'h06C, 0, 3); idle_wait(5);
    chk("R4 err irq on noise", {31'b0, err_irq}, 1);
    rd(2'd1, s); chk("R3 data-bit glitch noise", {31'b0, s[3]}, 1);
    rd(2'd2, v); chk("R3 majority data", v, 8'h6C);
    send(9'h06C, 0, 9); idle_wait(5);
    rd(2'd1, s); chk("R3 stop-bit glitch noise", {31'b0, s[3]}, 1);
    rd(2'd2, v); chk("R3 data after stop glitch", v, 8'h6C);
    send(9'h06C, 0, 0); idle_wait(5);
    rd(2'd1, s); chk("R3 start-bit glitch noise", {31'b0, s[3]}, 1);
    clr_flags();
    idle_wait(400); clr_flags();

    // R7 idle, count after start bit, 8-bit
    wr(8'h20);
    send(9'h0FF, 0, -1); idle_wait(10);
    rd(2'd1, s); chk("R7 idle not yet", {31'b0, s[1]}, 0);
    idle_wait(16);
    rd(2'd1, s); chk("R7 idle after 10 bits", {31'b0, s[1]}, 1);
    chk("R2 idle irq", {31'b0, rx_irq}, 1);
    rd(2'd2, v);
    idle_wait(400);
    rd(2'd1, s); chk("R8 idle not re-set", {31'b0, s[1]}, 0);

    // R7 idle counting from stop bit
    wr(8'h02);
    send(9'h0FF, 0, -1); idle_wait(30);
    rd(2'd1, s); chk("R7 stop-mode idle not yet", {31'b0, s[1]}, 0);
    idle_wait(136);
    rd(2'd1, s); chk("R7 stop-mode idle set", {31'b0, s[1]}, 1);
    rd(2'd2, v); idle_wait(50);

    // R7 9-bit idle threshold of 11 bits
    wr(8'h01);
    send(9'h1FF, 1, -1); idle_wait(6);
    rd(2'd1, s); chk("R7 9-bit idle not yet", {31'b0, s[1]}, 0);
    idle_wait(20);
    rd(2'd1, s); chk("R7 9-bit idle after 11 bits", {31'b0, s[1]}, 1);
    rd(2'd2, v); idle_wait(50);

    // R9 standby set on an idle line wakes at once
    wr(8'h04); idle_wait(3);
    rd(2'd0, v); chk("R9 immediate wake", {31'b0, v[2]}, 0);

    // R9 standby discards and masks
    wr(8'h10);
    send(9'h03C, 0, -1); idle_wait(5);
    chk("R2 ready irq before standby", {31'b0, rx_irq}, 1);
    fork
      send(9'h000, 0, -1);
      begin idle_wait(40); wr(8'h14); end
    join
    idle_wait(5);
    chk("R9 irq masked in standby", {31'b0, rx_irq}, 0);
    rd(2'd0, v); chk("R9 still in standby", {31'b0, v[2]}, 1);
    idle_wait(200);
    rd(2'd0, v); chk("R9 woke on idle", {31'b0, v[2]}, 0);
    chk("R9 irq restored", {31'b0, rx_irq}, 1);
    rd(2'd1, s); chk("R9 no overrun from discarded", {31'b0, s[2]}, 0);
    rd(2'd2, v); chk("R9 discarded char not loaded", v, 8'h3C);
    send(9'h04B, 0, -1); idle_wait(5);
    rd(2'd1, s); rd(2'd2, v); chk("R9 next char received", v, 8'h4B);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
    $finish;
  end
endmodule